// File: doc/BRIEF.md
# E1 Transmit Timeslot-0 Sa/Si Bit Inserter

This block builds timeslot 0 of every outgoing E1 frame on a serial bit stream. A bit-serial data input is copied to the serial output with one bit clock of delay. At the eight bit times of timeslot 0 the block puts its own bits on the line instead. In the alignment frame these are the fixed alignment word. In the non-alignment frame they are the forced 1 bit, the remote-alarm bit and the five spare (Sa) bits. In both frames the first bit is the international (Si) bit.

A host loads two 8-bit registers, one with the alignment-frame timeslot-0 image and one with the non-alignment-frame image. The block copies both into working registers once per double frame and raises a one-cycle status pulse at that moment. After the pulse the host has one full double frame (512 bit periods, 250 µs at 2.048 Mbit/s) to write the next values. If it writes nothing, the same values are sent again.

Each Sa bit can take its value either from the register or from a serial link input. A 5-bit mask chooses the source for each Sa bit separately. The Si bit follows a fixed priority:
1. the serial data input;
2. a CRC-4 bit input, when CRC-4 mode is on;
3. an E-bit input, when automatic E-bit insertion is on;
4. the register.

The CRC-4 and E-bit values are made outside the block.

Top module: `e1_ts0_inserter`

## Requirements
- R1: Frame positions.
  - A double frame is 512 bit periods: the alignment frame at positions 0..255, then the non-alignment frame at 256..511.
  - Timeslot 0 of each frame is its first 8 positions, TS0 bit n at frame offset n-1.
  - `frameSync` high in a cycle marks the `serIn` bit of that cycle as position 0. With no sync, the position advances by one per cycle and wraps from 511 to 0.
  - After reset release, the first cycle is position 511.
- R2: `alignStatus` is high for exactly one cycle per double frame. That cycle is the one in which position 0 is on `serIn`.
- R3: Both host registers are copied into the working registers at the clock edge that ends position 511.
  - A write whose enable is high in the cycle at position 510 is used for the next double frame.
  - A write in the cycle at position 511 is used one double frame later.
- R4: In the alignment frame, TS0 bits 2..8 are always 0,0,1,1,0,1,1, whatever the register holds.
- R5: In the non-alignment frame, TS0 bit 2 is always 1. TS0 bit 3 is 1 when `remoteAlarm` is high; otherwise it is non-alignment register bit 5.
- R6: In the non-alignment frame, TS0 bit 8-k (k = 4..0) is taken from `linkIn` when `saLinkMask[k]` is 1, and from non-alignment register bit k when it is 0.
- R7: TS0 bit 1 (Si) of either frame is chosen in this priority order:
  1. `serIn` when `siRegEn` is 0;
  2. otherwise `crc4Bit` when `crc4Mode` is 1;
  3. otherwise `eBitIn` when `autoEbit` is 1;
  4. otherwise bit 7 of the register for that frame.
- R8: Every bit outside timeslot 0 appears on `serOut` one clock after it is on `serIn`. With the mask all ones and `linkIn` carrying the same stream as `serIn`, the Sa bits also pass through unchanged.
- R9: During reset, `serOut` and `alignStatus` are 0, and both host registers and both working registers reset to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Marks position 0 of a double frame |
| serIn | input | 1 | Serial data input |
| linkIn | input | 1 | Serial link input for Sa bits |
| saLinkMask | input | 5 | Per-Sa-bit source select, 1 = link input |
| siRegEn | input | 1 | 1 = Si from register or mode inputs, 0 = Si from serIn |
| crc4Mode | input | 1 | CRC-4 mode on |
| crc4Bit | input | 1 | Externally generated CRC-4 Si value |
| autoEbit | input | 1 | Automatic E-bit insertion on |
| eBitIn | input | 1 | Externally generated E-bit value |
| remoteAlarm | input | 1 | Forces TS0 bit 3 of the non-alignment frame to 1 |
| afWrEn | input | 1 | Write strobe for the alignment-frame register |
| afWrData | input | 8 | Alignment-frame register data, bit 7 = TS0 bit 1 |
| nafWrEn | input | 1 | Write strobe for the non-alignment-frame register |
| nafWrData | input | 8 | Non-alignment-frame register data, bit 7 = TS0 bit 1 |
| serOut | output | 1 | Serial data output |
| alignStatus | output | 1 | One-cycle pulse when the registers are sampled |

## Verification
A position counter that is off by even one bit moves the whole timeslot-0 window. The alignment word, or a forced 1, then lands on a data bit. That mismatch shows on `serOut` within one frame, at most 256 cycles. It also shifts the `alignStatus` pulse, which the bench compares every cycle. A working register that loads at the wrong edge, or not at all, shows only in the register-sourced Si, remote-alarm and Sa bits, at the first timeslot 0 after the missed load. The directed writes at positions 510 and 511 make a load edge that is one cycle early or late change the Sa bits sent in the following double frame.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  localparam int TS_BITS = 8;
  localparam int BIT_IDX_W = $clog2(TS_BITS);
  localparam int SA_COUNT = 5;
  localparam int SI_REG_BIT = 7;
  localparam int ALARM_REG_BIT = 5;
  localparam logic [6:0] ALIGN_WORD = 7'b0011011;
  localparam logic [TS_BITS-1:0] REG_RESET = '1;

  typedef struct packed {
    logic                 ts0;       // current bit is inside timeslot 0
    logic                 nafFrame;  // current frame is the non-alignment frame
    logic [BIT_IDX_W-1:0] bitIdx;    // offset within the timeslot (0 = TS0 bit 1)
    logic                 loadWork;  // copy host registers at this edge
  } txStrobe_t;
endpackage

// File: rtl/e1_ts0_ctrl.sv
module e1_ts0_ctrl
  import e1_ts0_pkg::*;
#(
  parameter int FRAME_BITS = 256
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameSync,
  output txStrobe_t strb,
  output logic      alignStatus
);
  localparam int DF_BITS = 2 * FRAME_BITS;
  localparam int CNT_W = $clog2(DF_BITS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DF_BITS - 1);
  localparam logic [CNT_W-1:0] START_POS = CNT_W'(DF_BITS - 2);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] posNow;
  logic [CNT_W-1:0] inFrame;
  logic             inNaf;

  always_comb begin
    if (frameSync)
      posNow = '0;
    else if (cntQ == LAST_POS)
      posNow = '0;
    else
      posNow = cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      cntQ <= START_POS;
    else
      cntQ <= posNow;
  end

  always_comb begin
    inNaf = posNow >= CNT_W'(FRAME_BITS);
    inFrame = inNaf ? (posNow - CNT_W'(FRAME_BITS)) : posNow;
    strb.nafFrame = inNaf;
    strb.ts0 = inFrame < CNT_W'(TS_BITS);
    strb.bitIdx = inFrame[BIT_IDX_W-1:0];
    strb.loadWork = posNow == LAST_POS;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      alignStatus <= 1'b0;
    else
      alignStatus <= strb.loadWork;
  end

  // R1: a sync pulse always lands on TS0 bit 1 of the alignment frame
  a_r1_sync_is_start: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> (strb.ts0 && !strb.nafFrame && strb.bitIdx == '0));

  // R2: status follows the load strobe and lasts one cycle
  a_r2_status_after_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWork |=> alignStatus);
  a_r2_status_single: assert property (@(posedge clk) disable iff (!rstN)
    alignStatus |=> !alignStatus);
endmodule

// File: rtl/e1_ts0_datapath.sv
module e1_ts0_datapath
  import e1_ts0_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strb,
  input  logic                serIn,
  input  logic                linkIn,
  input  logic [SA_COUNT-1:0] saLinkMask,
  input  logic                siRegEn,
  input  logic                crc4Mode,
  input  logic                crc4Bit,
  input  logic                autoEbit,
  input  logic                eBitIn,
  input  logic                remoteAlarm,
  input  logic                afWrEn,
  input  logic [TS_BITS-1:0]  afWrData,
  input  logic                nafWrEn,
  input  logic [TS_BITS-1:0]  nafWrData,
  output logic                serOut
);
  logic [TS_BITS-1:0]   afHost, nafHost;
  logic [TS_BITS-1:0]   afWork, nafWork;
  logic [SA_COUNT-1:0]  saBit;
  logic [BIT_IDX_W-1:0] saIdx;
  logic                 siBit;
  logic                 nextBit;

  // host-side registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      afHost  <= REG_RESET;
      nafHost <= REG_RESET;
    end else begin
      if (afWrEn)  afHost  <= afWrData;
      if (nafWrEn) nafHost <= nafWrData;
    end
  end

  // working copies, refreshed once per double frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      afWork  <= REG_RESET;
      nafWork <= REG_RESET;
    end else if (strb.loadWork) begin
      afWork  <= afHost;
      nafWork <= nafHost;
    end
  end

  // per-Sa-bit source select
  for (genvar k = 0; k < SA_COUNT; k++) begin : g_saSel
    assign saBit[k] = saLinkMask[k] ? linkIn : nafWork[k];
  end

  assign saIdx = BIT_IDX_W'(TS_BITS - 1) - strb.bitIdx;

  always_comb begin
    if (!siRegEn)
      siBit = serIn;
    else if (crc4Mode)
      siBit = crc4Bit;
    else if (autoEbit)
      siBit = eBitIn;
    else
      siBit = strb.nafFrame ? nafWork[SI_REG_BIT] : afWork[SI_REG_BIT];
  end

  always_comb begin
    nextBit = serIn;
    if (strb.ts0) begin
      if (strb.bitIdx == '0)
        nextBit = siBit;
      else if (!strb.nafFrame)
        nextBit = ALIGN_WORD[saIdx];
      else if (strb.bitIdx == BIT_IDX_W'(1))
        nextBit = 1'b1;
      else if (strb.bitIdx == BIT_IDX_W'(2))
        nextBit = remoteAlarm | nafWork[ALARM_REG_BIT];
      else
        nextBit = saBit[saIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      serOut <= 1'b0;
    else
      serOut <= nextBit;
  end

  // R8: data outside timeslot 0 is delayed by exactly one clock
  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ts0 |=> serOut == $past(serIn));

  // R5: non-alignment bit 2 is always one
  a_r5_naf_bit2_one: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ts0 && strb.nafFrame && strb.bitIdx == BIT_IDX_W'(1)) |=> serOut);

  // R6: a linked Sa bit carries the link input
  a_r6_sa_from_link: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ts0 && strb.nafFrame && strb.bitIdx >= BIT_IDX_W'(3) && saLinkMask[saIdx])
      |=> serOut == $past(linkIn));

  // R7: serial input wins the Si priority
  a_r7_si_serial: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ts0 && strb.bitIdx == '0 && !siRegEn) |=> serOut == $past(serIn));

  // R3: working copies change only at the load edge
  a_r3_work_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadWork |=> ($stable(afWork) && $stable(nafWork)));
endmodule

// File: rtl/e1_ts0_inserter.sv
module e1_ts0_inserter
  import e1_ts0_pkg::*;
#(
  parameter int FRAME_BITS = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameSync,
  input  logic                serIn,
  input  logic                linkIn,
  input  logic [SA_COUNT-1:0] saLinkMask,
  input  logic                siRegEn,
  input  logic                crc4Mode,
  input  logic                crc4Bit,
  input  logic                autoEbit,
  input  logic                eBitIn,
  input  logic                remoteAlarm,
  input  logic                afWrEn,
  input  logic [TS_BITS-1:0]  afWrData,
  input  logic                nafWrEn,
  input  logic [TS_BITS-1:0]  nafWrData,
  output logic                serOut,
  output logic                alignStatus
);
  txStrobe_t strb;

  e1_ts0_ctrl #(.FRAME_BITS(FRAME_BITS)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameSync  (frameSync),
    .strb       (strb),
    .alignStatus(alignStatus)
  );

  e1_ts0_datapath i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .serIn      (serIn),
    .linkIn     (linkIn),
    .saLinkMask (saLinkMask),
    .siRegEn    (siRegEn),
    .crc4Mode   (crc4Mode),
    .crc4Bit    (crc4Bit),
    .autoEbit   (autoEbit),
    .eBitIn     (eBitIn),
    .remoteAlarm(remoteAlarm),
    .afWrEn     (afWrEn),
    .afWrData   (afWrData),
    .nafWrEn    (nafWrEn),
    .nafWrData  (nafWrData),
    .serOut     (serOut)
  );
endmodule

// File: tb/test_e1_ts0_inserter.sv
module test_e1_ts0_inserter;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 256;
  localparam int DF = 2 * FRAME;
  localparam logic [6:0] ALIGN = 7'b0011011;

  logic clk = 1'b0;
  logic rstN;
  logic frameSync, serIn, linkIn;
  logic [4:0] saLinkMask;
  logic siRegEn, crc4Mode, crc4Bit, autoEbit, eBitIn, remoteAlarm;
  logic afWrEn, nafWrEn;
  logic [7:0] afWrData, nafWrData;
  logic serOut, alignStatus;

  int checks = 0;
  int errors = 0;
  int pos;
  int syncAge;
  logic [7:0] mAf, mNaf, wAf, wNaf;
  logic expOut, expStat;
  bit havePrev;
  string expTag;
  bit knobPass, knobLate, knobRandCtl, knobAlignSync;
  bit done = 0;

  e1_ts0_inserter i_e1_ts0_inserter (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .serIn(serIn), .linkIn(linkIn),
    .saLinkMask(saLinkMask), .siRegEn(siRegEn), .crc4Mode(crc4Mode), .crc4Bit(crc4Bit),
    .autoEbit(autoEbit), .eBitIn(eBitIn), .remoteAlarm(remoteAlarm),
    .afWrEn(afWrEn), .afWrData(afWrData), .nafWrEn(nafWrEn), .nafWrData(nafWrData),
    .serOut(serOut), .alignStatus(alignStatus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, logic act, logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // expected output bit for a position, from the requirements
  task automatic computeExp(int p);
    bit naf;
    int b;
    int k;
    naf = p >= FRAME;
    b = naf ? p - FRAME : p;
    if (b >= 8) begin
      expOut = serIn; expTag = "R8";
    end else if (b == 0) begin
      expTag = "R7";
      if (!siRegEn) expOut = serIn;
      else if (crc4Mode) expOut = crc4Bit;
      else if (autoEbit) expOut = eBitIn;
      else begin
        expOut = naf ? wNaf[7] : wAf[7];
        if (knobLate) expTag = "R3";
      end
    end else if (!naf) begin
      expOut = ALIGN[7-b]; expTag = "R4";
    end else if (b == 1) begin
      expOut = 1'b1; expTag = "R5";
    end else if (b == 2) begin
      expOut = remoteAlarm | wNaf[5]; expTag = "R5";
    end else begin
      k = 7 - b;
      expOut = saLinkMask[k] ? linkIn : wNaf[k];
      expTag = knobPass ? "R8 Sa pass-through" : ((knobLate && !saLinkMask[k]) ? "R3" : "R6");
    end
    if (syncAge < 8) expTag = "R1";
  endtask

  task automatic randCtl();
    saLinkMask = 5'($urandom);
    siRegEn = 1'($urandom);
    crc4Mode = 1'($urandom);
    autoEbit = 1'($urandom);
    remoteAlarm = 1'($urandom);
  endtask

  task automatic stepCycle(bit forceSync);
    int nat;
    int posNow;
    bit doSync;
    if (havePrev) begin
      check(serOut === expOut, expTag, serOut, expOut);
      check(alignStatus === expStat, "R2", alignStatus, expStat);
    end
    nat = (pos == DF - 1) ? 0 : pos + 1;
    doSync = forceSync || (knobAlignSync && nat == 0);
    posNow = doSync ? 0 : nat;
    if (knobRandCtl && posNow == DF - 1) randCtl();
    frameSync = doSync;
    serIn = 1'($urandom);
    linkIn = knobPass ? serIn : 1'($urandom);
    crc4Bit = 1'($urandom);
    eBitIn = 1'($urandom);
    afWrEn = 1'b0; nafWrEn = 1'b0;
    afWrData = 8'($urandom); nafWrData = 8'($urandom);
    if (knobLate) begin
      // R3: late writes at the last two positions
      if (posNow == DF - 2 || posNow == DF - 1) begin
        afWrEn = 1'b1; nafWrEn = 1'b1;
      end
    end else if ($urandom % 97 == 0) begin
      afWrEn = 1'($urandom); nafWrEn = 1'($urandom);
    end
    if (forceSync && nat != 0) syncAge = 0; else syncAge++;
    computeExp(posNow);
    expStat = posNow == DF - 1;
    if (posNow == DF - 1) begin wAf = mAf; wNaf = mNaf; end
    if (afWrEn) mAf = afWrData;
    if (nafWrEn) mNaf = nafWrData;
    pos = posNow;
    havePrev = 1;
    @(negedge clk);
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) stepCycle(1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; frameSync = 0; serIn = 0; linkIn = 0; saLinkMask = 0;
    siRegEn = 1; crc4Mode = 0; crc4Bit = 0; autoEbit = 0; eBitIn = 0; remoteAlarm = 0;
    afWrEn = 0; nafWrEn = 0; afWrData = 0; nafWrData = 0;
    mAf = 8'hFF; mNaf = 8'hFF; wAf = 8'hFF; wNaf = 8'hFF;
    pos = DF - 2; syncAge = 100; havePrev = 0;
    knobPass = 0; knobLate = 0; knobRandCtl = 0; knobAlignSync = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(serOut === 1'b0, "R9 serOut", serOut, 1'b0);
    check(alignStatus === 1'b0, "R9 alignStatus", alignStatus, 1'b0);
    rstN = 1'b1;

    // first double frame with register-sourced Sa/Si, reset values all ones (R9)
    runCycles(DF);

    // random controls with aligned sync pulses
    knobRandCtl = 1; knobAlignSync = 1;
    runCycles(4 * DF);

    // every Si source combination (R7)
    knobRandCtl = 0;
    for (int c = 0; c < 8; c++) begin
      siRegEn = c[0]; crc4Mode = c[1]; autoEbit = c[2];
      saLinkMask = 5'($urandom); remoteAlarm = 1'($urandom);
      runCycles(DF);
    end

    // Sa pass-through: all Sa from link, link mirrors serial input (R8)
    knobPass = 1; saLinkMask = 5'h1F; siRegEn = 0;
    runCycles(2 * DF);
    knobPass = 0;

    // late writes at positions 510 and 511 (R3)
    knobLate = 1; saLinkMask = 5'h00; siRegEn = 1; crc4Mode = 0; autoEbit = 0; remoteAlarm = 0;
    runCycles(3 * DF);
    knobLate = 0;

    // re-synchronisation in the middle of a frame (R1)
    knobRandCtl = 1;
    runCycles(100);
    stepCycle(1'b1);
    runCycles(2 * DF);
    runCycles(300);
    stepCycle(1'b1);
    runCycles(DF + 20);
    stepCycle(1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule